// File: doc/BRIEF.md
# Multi-Mode Host Bus Bridge

This block lets an external host reach an internal register file over one of four bus styles: an Intel-style bus with separate address pins, a Motorola-style bus, an Intel-style bus that multiplexes address and data, or a four-wire serial port. All styles are reduced to one internal register port. That port carries a 7-bit address, 8-bit write data, a one-cycle write pulse, a one-cycle read strobe, and read data that the register file returns in the same cycle as the strobe.

The style is found while the chip runs. A static mode-select pin chooses between the two non-multiplexed styles as long as the shared address-latch / serial-clock pin stays quiet. The first edge seen on that shared pin, rising or falling, locks the block into the multiplexed style (select low) or the serial style (select high). Only a hardware reset releases the lock.

Every host pin is brought into the core clock through a two-flop synchronizer, and all decoding runs in the core clock. The host bus as a whole is active only while the chip-level microprocessor-mode input is high.

Top module: `host_bus_bridge`

## Requirements
- R1: After reset, with the select pin low, `host_mode` reads 0. No write pulse and no read strobe occur, and `bus_doe` and `ser_dout` are 0.
- R2: While no shared-pin edge has been seen, `host_mode` follows the select pin: 0 (Intel separate address) when it is low and 1 (Motorola) when it is high.
- R3: An edge of either polarity on `bus_ale_sclk` sets `host_mode` to 2 (multiplexed) if the select pin is low, or to 3 (serial) if it is high.
- R4: Once `host_mode` is 2 or 3, it does not change on later select-pin changes or shared-pin edges until reset. A reset brings back the unlocked behaviour.
- R5: In modes 0 and 2, asserting `bus_cs_n` and `bus_wr_n` low gives exactly one write pulse, with the data from `bus_din`. In mode 0 the address comes from `bus_addr`.
- R6: In modes 0 and 2, asserting `bus_cs_n` and `bus_rd_n` low gives exactly one read strobe. The returned byte appears on `bus_dout` with `bus_doe` high, and `bus_doe` stays high until the strobe is released, then goes low.
- R7: In mode 1, `bus_wr_n` carries read-not-write (1 = read, 0 = write) and `bus_rd_n` carries the active-low data strobe. A cycle needs both `bus_cs_n` and the data strobe low. Data strobe low while chip select is high does nothing.
- R8: In mode 2, the falling edge of `bus_ale_sclk` captures the address from `bus_din[6:0]`. The next read or write uses that address and ignores `bus_addr`.
- R9: In mode 3, a frame sampled on rising `bus_ale_sclk` edges while `bus_cs_n` is low is: one direction bit (0 = write, 1 = read), then 7 address bits MSB first, then 8 data bits MSB first. A write frame gives one write pulse after its 16th bit.
- R10: In a serial read frame, one read strobe is issued after the 8th bit. The byte is shifted out on `ser_dout` MSB first, one bit per falling edge, starting with the falling edge that follows the 8th bit.
- R11: `bus_cs_n` high in mode 3 aborts the frame. The next frame starts again from its direction bit.
- R12: While `host_en` is low, host strobes cause no write pulse and no read strobe, and `bus_doe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_en | input | 1 | Chip is in microprocessor mode; host bus enabled |
| bus_cs_n | input | 1 | Chip select, active low (all modes) |
| bus_wr_n | input | 1 | Write strobe (modes 0, 2) or read-not-write (mode 1) |
| bus_rd_n | input | 1 | Read strobe (modes 0, 2) or data strobe (mode 1) |
| bus_ale_sclk | input | 1 | Shared address-latch enable / serial clock |
| bus_msel | input | 1 | Static mode-select pin |
| bus_addr | input | 7 | Address pins for modes 0 and 1 |
| bus_din | input | 8 | Data bus in; address phase in mode 2 |
| bus_dout | output | 8 | Read data to the host |
| bus_doe | output | 1 | Read data is being driven |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out |
| host_mode | output | 2 | Active style: 0 Intel, 1 Motorola, 2 multiplexed, 3 serial |
| reg_addr | output | 7 | Register port address |
| reg_wdata | output | 8 | Register port write data |
| reg_we | output | 1 | One-cycle write pulse |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data returned in the strobe cycle |

## Verification
A pin change passes two synchronizer flops. The internal strobe therefore rises in the cycle after the second core edge, and registered results follow at the third edge. That covers `host_mode` after a select change or a lock, `bus_doe`/`bus_dout` after a read strobe, and `ser_dout` after a serial-clock fall. Every directed task holds each pin level for four core cycles and samples on the falling clock edge after that hold, which is one cycle beyond the latest of these results. A falling-edge monitor counts the write pulses and read strobes and records the address and data at each one. Each check compares the change in those counts with an exact value, which catches both missing pulses and repeated ones.

// File: rtl/hb_pkg.sv
// Shared types for the host bus bridge.
package hb_pkg;
    // Active host bus style; the numeric codes are visible on host_mode.
    typedef enum logic [1:0] {
        HB_INTEL = 2'd0,
        HB_MOTO  = 2'd1,
        HB_MUX   = 2'd2,
        HB_SER   = 2'd3
    } hb_mode_e;
endpackage

// File: rtl/hb_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous pins.
// Assumes each bit is sampled on its own; the bits are not treated as a coherent bus.
module hb_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage resample into the core clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/hb_mode_detect.sv
// Decides the active host bus style and reports edges of the shared pin.
// Assumes synchronized inputs. Edges are ignored for three cycles after reset,
// so a shared pin that is high at reset cannot look like an edge.
module hb_mode_detect
    import hb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     shr_s,
    input  logic     msel_s,
    output hb_mode_e mode,
    output logic     shr_rise,
    output logic     shr_fall
);
    logic       shr_prev_q;
    logic [1:0] arm_q;
    logic [1:0] lock_q;
    logic       armed;

    assign armed    = (arm_q == 2'd3);
    assign shr_rise = armed &  shr_s & ~shr_prev_q;
    assign shr_fall = armed & ~shr_s &  shr_prev_q;
    assign mode     = lock_q[1] ? hb_mode_e'(lock_q) : (msel_s ? HB_MOTO : HB_INTEL);

    // Keep the previous shared-pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) shr_prev_q <= 1'b0;
        else        shr_prev_q <= shr_s;
    end

    // Count the settling cycles after reset before edges are trusted.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_q <= 2'd0;
        else if (!armed) arm_q <= arm_q + 2'd1;
    end

    // Sticky lock: the first edge picks mux or serial; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 2'b00;
        else if (!lock_q[1] && (shr_rise || shr_fall))
            lock_q <= {1'b1, msel_s};
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[1] |=> (lock_q == $past(lock_q))); // R4
    AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q[1] && (shr_rise || shr_fall)) |=> (lock_q == {1'b1, $past(msel_s)})); // R3
endmodule

// File: rtl/hb_par_decode.sv
// Turns the three parallel bus styles into register port strobes.
// Assumes synchronized control pins, and address/data pins that stay stable
// while a strobe is active and for three cycles after ALE falls.
module hb_par_decode
    import hb_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  hb_mode_e          mode,
    input  logic              cs_s,
    input  logic              wr_s,
    input  logic              rd_s,
    input  logic              ale_fall,
    input  logic [ADDR_W-1:0] addr_pins,
    input  logic [DATA_W-1:0] data_pins,
    input  logic [DATA_W-1:0] rdata,
    output logic              we,
    output logic              re,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dout,
    output logic              doe
);
    logic              act_wr, act_rd;
    logic              act_wr_q, act_rd_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [DATA_W-1:0] rd_data_q;

    // Decode the active write and read conditions for the current style.
    always_comb begin
        act_wr = 1'b0;
        act_rd = 1'b0;
        if (en && !cs_s) begin
            if (mode == HB_MOTO) begin
                act_wr = !rd_s && !wr_s;
                act_rd = !rd_s &&  wr_s;
            end else begin
                act_wr = !wr_s;
                act_rd = !rd_s;
            end
        end
    end

    assign we    = act_wr & ~act_wr_q;
    assign re    = act_rd & ~act_rd_q;
    assign addr  = (mode == HB_MUX) ? lat_addr_q : addr_pins;
    assign wdata = data_pins;
    assign dout  = rd_data_q;
    assign doe   = act_rd_q;

    // Remember strobe activity to form one pulse per host cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_wr_q <= 1'b0;
            act_rd_q <= 1'b0;
        end else begin
            act_wr_q <= act_wr;
            act_rd_q <= act_rd;
        end
    end

    // Capture the multiplexed address when ALE falls.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lat_addr_q <= '0;
        else if (mode == HB_MUX && ale_fall) lat_addr_q <= data_pins[ADDR_W-1:0];
    end

    // Hold the returned byte for the whole read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rd_data_q <= '0;
        else if (re) rd_data_q <= rdata;
    end

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we); // R5
    AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> !re); // R6
    AST_OE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (doe && $past(doe)) |-> $stable(dout)); // R6
endmodule

// File: rtl/hb_ser_decode.sv
// Serial frame decoder: a direction bit, an address and data, all MSB first.
// Samples input on rising clock edges and shifts output on falling edges.
// Chip select high clears the frame. Assumes synchronized pins.
module hb_ser_decode #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cs_s,
    input  logic              sdi_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic [DATA_W-1:0] rdata,
    output logic              we,
    output logic              re,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              sdo
);
    localparam int HDR_N   = 1 + ADDR_W;
    localparam int FRAME_W = HDR_N + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_N - 1);
    localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_N);
    localparam logic [CNT_W-1:0] FRM_CNT  = CNT_W'(FRAME_W);

    logic              go;
    logic [CNT_W-1:0]  cnt_q;
    logic [FRAME_W-2:0] sr_q;
    logic [DATA_W-1:0] tx_q;
    logic              rd_frame_q;
    logic              sdo_q;
    logic              at_hdr, at_end;

    assign go     = en & ~cs_s;
    assign at_hdr = go && sck_rise && (cnt_q == HDR_LAST);
    assign at_end = go && sck_rise && (cnt_q == FRM_LAST);
    assign re     = at_hdr &  sr_q[HDR_N-2];
    assign we     = at_end & ~sr_q[FRAME_W-2];
    assign addr   = (cnt_q == HDR_LAST) ? {sr_q[ADDR_W-2:0], sdi_s}
                                        : sr_q[FRAME_W-3:DATA_W-1];
    assign wdata  = {sr_q[DATA_W-2:0], sdi_s};
    assign sdo    = sdo_q;

    // Count and shift in the frame bits; chip select high restarts the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (sck_rise && cnt_q < FRM_CNT) begin
            cnt_q <= cnt_q + 1'b1;
            sr_q  <= {sr_q[FRAME_W-3:0], sdi_s};
        end
    end

    // Load the read byte and shift it out on falling serial clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            tx_q       <= '0;
            rd_frame_q <= 1'b0;
            sdo_q      <= 1'b0;
        end else if (re) begin
            tx_q       <= rdata;
            rd_frame_q <= 1'b1;
        end else if (sck_fall && rd_frame_q && cnt_q >= HDR_CNT && cnt_q < FRM_CNT) begin
            sdo_q <= tx_q[DATA_W-1];
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FRM_CNT); // R9
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (cnt_q == '0)); // R11
    AST_SER_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re)); // R10
endmodule

// File: rtl/host_bus_bridge.sv
// Top level of the multi-mode host bus bridge. It synchronizes the host pins,
// settles the bus style, and merges the parallel and serial decoders onto
// one register port. Assumes the register file answers reads in the strobe cycle.
module host_bus_bridge
    import hb_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic              bus_ale_sclk,
    input  logic              bus_msel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic [1:0]        host_mode,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int NSYNC = 6;
    localparam logic [NSYNC-1:0] SYNC_RST = 6'b111_000;

    logic [NSYNC-1:0] pins_s;
    logic             cs_s, wr_s, rd_s, shr_s, msel_s, sdi_s;
    hb_mode_e         mode;
    logic             shr_rise, shr_fall;
    logic             p_we, p_re, s_we, s_re;
    logic [ADDR_W-1:0] p_addr, s_addr;
    logic [DATA_W-1:0] p_wdata, s_wdata;
    logic             ser_sel;

    hb_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_cs_n, bus_wr_n, bus_rd_n, bus_ale_sclk, bus_msel, ser_din}),
        .q     (pins_s)
    );
    assign {cs_s, wr_s, rd_s, shr_s, msel_s, sdi_s} = pins_s;

    hb_mode_detect u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .shr_s    (shr_s),
        .msel_s   (msel_s),
        .mode     (mode),
        .shr_rise (shr_rise),
        .shr_fall (shr_fall)
    );

    assign ser_sel = (mode == HB_SER);

    hb_par_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (host_en & ~ser_sel),
        .mode      (mode),
        .cs_s      (cs_s),
        .wr_s      (wr_s),
        .rd_s      (rd_s),
        .ale_fall  (shr_fall),
        .addr_pins (bus_addr),
        .data_pins (bus_din),
        .rdata     (reg_rdata),
        .we        (p_we),
        .re        (p_re),
        .addr      (p_addr),
        .wdata     (p_wdata),
        .dout      (bus_dout),
        .doe       (bus_doe)
    );

    hb_ser_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (host_en & ser_sel),
        .cs_s     (cs_s),
        .sdi_s    (sdi_s),
        .sck_rise (shr_rise),
        .sck_fall (shr_fall),
        .rdata    (reg_rdata),
        .we       (s_we),
        .re       (s_re),
        .addr     (s_addr),
        .wdata    (s_wdata),
        .sdo      (ser_dout)
    );

    assign host_mode = mode;
    assign reg_we    = p_we | s_we;
    assign reg_re    = p_re | s_re;
    assign reg_addr  = ser_sel ? s_addr  : p_addr;
    assign reg_wdata = ser_sel ? s_wdata : p_wdata;

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re)); // R5
    AST_OE_PARALLEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> ($past(host_mode) != 2'd3)); // R6
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_en && !$past(host_en)) |-> (!reg_we && !reg_re)); // R12
endmodule

// File: tb/sim_host_bus_bridge.sv
module sim_host_bus_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_en = 1'b0;
    logic       bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
    logic       bus_ale_sclk = 1'b0, bus_msel = 1'b0, ser_din = 1'b0;
    logic [6:0] bus_addr = '0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout, reg_wdata, reg_rdata;
    logic       bus_doe, ser_dout, reg_we, reg_re;
    logic [1:0] host_mode;
    logic [6:0] reg_addr;

    int checks = 0, errors = 0;
    int we_cnt = 0, re_cnt = 0;
    logic [6:0] last_waddr, last_raddr;
    logic [7:0] last_wdata;
    bit done = 0;

    always #4 clk = ~clk;

    host_bus_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_en(host_en), .bus_cs_n(bus_cs_n),
        .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_ale_sclk(bus_ale_sclk),
        .bus_msel(bus_msel), .bus_addr(bus_addr), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .ser_din(ser_din),
        .ser_dout(ser_dout), .host_mode(host_mode), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] rf(input logic [6:0] a);
        return {a[3:0], a[6:4], 1'b1} ^ 8'h3C;
    endfunction
    assign reg_rdata = rf(reg_addr);

    always @(negedge clk) begin
        if (reg_we) begin we_cnt++; last_waddr = reg_addr; last_wdata = reg_wdata; end
        if (reg_re) begin re_cnt++; last_raddr = reg_addr; end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic msel);
        bus_msel = msel; bus_ale_sclk = 1'b0; bus_cs_n = 1'b1;
        bus_wr_n = 1'b1; bus_rd_n = 1'b1; ser_din = 1'b0;
        rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(5);
    endtask

    task automatic par_write(input logic [6:0] a, input logic [7:0] d);
        bus_addr = a; bus_din = d; bus_cs_n = 1'b0; bus_wr_n = 1'b0; tick(6);
        bus_cs_n = 1'b1; bus_wr_n = 1'b1; tick(6);
    endtask

    task automatic ale_addr(input logic [6:0] a);
        bus_din = {1'b0, a}; bus_ale_sclk = 1'b1; tick(4);
        bus_ale_sclk = 1'b0; tick(4);
    endtask

    task automatic ser_bit(input logic b);
        ser_din = b; tick(4); bus_ale_sclk = 1'b1; tick(4); bus_ale_sclk = 1'b0; tick(4);
    endtask

    task automatic t_reset;
        do_reset(1'b0); host_en = 1'b1;
        chk(host_mode == 2'd0, "R1 mode", host_mode, 0);
        chk(!bus_doe && !ser_dout, "R1 outputs", {bus_doe, ser_dout}, 0);
        chk(we_cnt == 0 && re_cnt == 0, "R1 strobes", we_cnt + re_cnt, 0);
    endtask

    task automatic t_intel;
        int w0 = we_cnt, r0 = re_cnt;
        par_write(7'h15, 8'hA7);
        chk(we_cnt == w0 + 1, "R5 one pulse", we_cnt - w0, 1);
        chk(last_waddr == 7'h15 && last_wdata == 8'hA7, "R5 addr/data",
            {last_waddr, last_wdata}, {7'h15, 8'hA7});
        bus_addr = 7'h22; bus_cs_n = 1'b0; bus_rd_n = 1'b0; tick(6);
        chk(re_cnt == r0 + 1, "R6 one strobe", re_cnt - r0, 1);
        chk(bus_doe && bus_dout == rf(7'h22), "R6 data", {bus_doe, bus_dout}, {1'b1, rf(7'h22)});
        bus_cs_n = 1'b1; bus_rd_n = 1'b1; tick(6);
        chk(!bus_doe, "R6 release", bus_doe, 0);
    endtask

    task automatic t_disabled;
        int w0 = we_cnt, r0 = re_cnt;
        host_en = 1'b0; tick(2);
        par_write(7'h01, 8'h55);
        bus_cs_n = 1'b0; bus_rd_n = 1'b0; tick(6);
        chk(!bus_doe, "R12 no drive", bus_doe, 0);
        bus_cs_n = 1'b1; bus_rd_n = 1'b1; tick(6);
        chk(we_cnt == w0 && re_cnt == r0, "R12 ignored", we_cnt - w0 + re_cnt - r0, 0);
        host_en = 1'b1; tick(2);
    endtask

    task automatic t_moto;
        int w0, r0;
        bus_msel = 1'b1; tick(4);
        chk(host_mode == 2'd1, "R2 motorola", host_mode, 1);
        w0 = we_cnt; r0 = re_cnt;
        bus_addr = 7'h4C; bus_din = 8'h3E; bus_wr_n = 1'b0; bus_cs_n = 1'b0; bus_rd_n = 1'b0; tick(6);
        bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1; tick(6);
        chk(we_cnt == w0 + 1 && last_waddr == 7'h4C && last_wdata == 8'h3E, "R7 write",
            {last_waddr, last_wdata}, {7'h4C, 8'h3E});
        bus_addr = 7'h09; bus_cs_n = 1'b0; bus_rd_n = 1'b0; tick(6);
        chk(bus_doe && bus_dout == rf(7'h09) && re_cnt == r0 + 1, "R7 read",
            bus_dout, rf(7'h09));
        bus_cs_n = 1'b1; bus_rd_n = 1'b1; tick(6);
        w0 = we_cnt; r0 = re_cnt;
        bus_wr_n = 1'b0; bus_rd_n = 1'b0; tick(6);
        bus_rd_n = 1'b1; bus_wr_n = 1'b1; tick(6);
        chk(we_cnt == w0 && re_cnt == r0, "R7 needs cs", we_cnt - w0 + re_cnt - r0, 0);
        bus_msel = 1'b0; tick(4);
        chk(host_mode == 2'd0, "R2 intel", host_mode, 0);
    endtask

    task automatic t_mux;
        int r0;
        do_reset(1'b0);
        ale_addr(7'h3B);
        chk(host_mode == 2'd2, "R3 mux lock", host_mode, 2);
        bus_addr = 7'h70; bus_din = 8'hC4; bus_cs_n = 1'b0; bus_wr_n = 1'b0; tick(6);
        bus_cs_n = 1'b1; bus_wr_n = 1'b1; tick(6);
        chk(last_waddr == 7'h3B && last_wdata == 8'hC4, "R8 latched write",
            {last_waddr, last_wdata}, {7'h3B, 8'hC4});
        ale_addr(7'h11);
        r0 = re_cnt;
        bus_cs_n = 1'b0; bus_rd_n = 1'b0; tick(6);
        chk(re_cnt == r0 + 1 && last_raddr == 7'h11 && bus_dout == rf(7'h11), "R8 latched read",
            bus_dout, rf(7'h11));
        bus_cs_n = 1'b1; bus_rd_n = 1'b1; tick(6);
        bus_msel = 1'b1; tick(5);
        ale_addr(7'h02);
        chk(host_mode == 2'd2, "R4 mux sticky", host_mode, 2);
    endtask

    task automatic ser_frame(input logic rw, input logic [6:0] a, input logic [7:0] d);
        ser_bit(rw);
        for (int i = 6; i >= 0; i--) ser_bit(a[i]);
        for (int i = 7; i >= 0; i--) ser_bit(d[i]);
    endtask

    task automatic t_serial;
        int w0, r0;
        logic [7:0] exp;
        do_reset(1'b1);
        bus_ale_sclk = 1'b1; tick(4); bus_ale_sclk = 1'b0; tick(4);
        chk(host_mode == 2'd3, "R3 serial lock", host_mode, 3);
        w0 = we_cnt;
        bus_cs_n = 1'b0; tick(4);
        ser_frame(1'b0, 7'h5A, 8'h96);
        bus_cs_n = 1'b1; tick(4);
        chk(we_cnt == w0 + 1 && last_waddr == 7'h5A && last_wdata == 8'h96, "R9 write frame",
            {last_waddr, last_wdata}, {7'h5A, 8'h96});
        r0 = re_cnt; exp = rf(7'h07);
        bus_cs_n = 1'b0; tick(4);
        ser_bit(1'b1);
        for (int i = 6; i >= 0; i--) ser_bit(1'(7'h07 >> i));
        chk(re_cnt == r0 + 1 && last_raddr == 7'h07, "R10 read strobe", last_raddr, 7'h07);
        for (int i = 7; i >= 0; i--) begin
            chk(ser_dout == exp[i], "R10 sdo bit", ser_dout, exp[i]);
            if (i > 0) ser_bit(1'b0);
        end
        ser_bit(1'b0);
        bus_cs_n = 1'b1; tick(4);
        w0 = we_cnt;
        bus_cs_n = 1'b0; tick(4);
        for (int i = 0; i < 5; i++) ser_bit(1'b1);
        bus_cs_n = 1'b1; tick(4); bus_cs_n = 1'b0; tick(4);
        ser_frame(1'b0, 7'h33, 8'h81);
        bus_cs_n = 1'b1; tick(4);
        chk(we_cnt == w0 + 1 && last_waddr == 7'h33 && last_wdata == 8'h81, "R11 abort",
            {last_waddr, last_wdata}, {7'h33, 8'h81});
        bus_msel = 1'b0; tick(5);
        chk(host_mode == 2'd3, "R4 serial sticky", host_mode, 3);
        do_reset(1'b0);
        chk(host_mode == 2'd0, "R4 reset unlocks", host_mode, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_intel();
        t_disabled();
        t_moto();
        t_mux();
        t_serial();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule